// File: doc/BRIEF.md
# DAC Reset Sequencer and Power Control

This block sits beside the register file of a multichannel DAC. It owns the chip-level control register and the timed default-load sequence. The external reset pin is active low. The sequence starts only when that pin returns high. The pin is brought into the system clock domain through a synchroniser, and only its rising edge counts. While the pin stays low, nothing happens.

Each sequence lasts `SEQ_CYCLES` clocks and holds a write inhibit high for that whole window. In its first cycles it issues one default-load strobe per register. It walks the channels in ascending order and, inside each channel, the data, gain and offset registers. The sequence also clears the control register.

The control register has three bits:
- A power-down bit, which parks every output on signal ground.
- A thermal-shutdown enable.
- A sticky over-temperature flag. It is set when the enable is on and the synchronised comparator input is high. It is released only by writing the enable back to zero.

Top module: `dac_rst_pwr_ctrl`

## Requirements
- R1: A low level or a falling edge on `rst_pin_n` starts no sequence. There is no strobe and `wr_inhibit` stays low.
- R2: After a rising edge of `rst_pin_n` passes the synchroniser, `wr_inhibit` is high for exactly `SEQ_CYCLES` consecutive cycles.
- R3: Each sequence issues exactly 3×`NUM_CH` `load_strobe` pulses on consecutive cycles, starting in the first inhibited cycle. `load_ch` runs from 0 upward. Within each channel, `load_kind` runs 0 (data), 1 (gain), 2 (offset).
- R4: Writing `ctrl_wdata[0]`=1 sets status bit 0 and drives `pwr_down` high. Writing it to 0 releases `pwr_down`, provided the over-temperature flag is clear.
- R5: With the enable set by `ctrl_wdata[1]`=1 (status bit 1), a high `ot_in` sets status bit 4 and drives `pwr_down` high.
- R6: With the enable clear, `ot_in` is ignored: status bit 4 and `pwr_down` stay low.
- R7: Status bit 4 stays set after `ot_in` falls. It is cleared only by a write with `ctrl_wdata[1]`=0, which also clears bit 1.
- R8: Control writes made while `wr_inhibit` is high are ignored.
- R9: The start of a sequence clears all control bits, so status reads 0x00.
- R10: A new rising edge during a sequence restarts it from channel 0. Inhibit continues without a gap for a full `SEQ_CYCLES` from the restart.
- R11: After `rst`, status is 0x00 and `wr_inhibit`, `pwr_down` and `load_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin; sequence starts on its rise |
| ot_in | input | 1 | Asynchronous over-temperature comparator output |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 2 | Bit 0 power-down, bit 1 thermal-shutdown enable |
| load_strobe | output | 1 | Default-load strobe for the addressed register |
| load_ch | output | $clog2(NUM_CH) | Channel of the register being defaulted |
| load_kind | output | 2 | 0 data, 1 gain, 2 offset |
| wr_inhibit | output | 1 | High while the sequence runs |
| pwr_down | output | 1 | Route all outputs to signal ground |
| status | output | 8 | Bit 0 power-down, bit 1 enable, bit 4 over-temperature flag, rest 0 |

## Verification
The bench holds the pin low for a while to prove that a level starts nothing. A level-triggered design would strobe at once. It pulls the pin low part way through a sequence and checks that the restart begins again at channel 0 with a full-length inhibit. A design that only retriggers when idle would end early or skip registers. It lets the comparator fall while the flag is latched and expects the flag to stay. A design that merely follows the comparator would release `pwr_down`. It writes the control register inside the inhibit window and expects the write to leave no trace.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic [1:0] {
        KIND_DATA   = 2'd0,
        KIND_GAIN   = 2'd1,
        KIND_OFFSET = 2'd2
    } reg_kind_e;

    localparam int unsigned KINDS_PER_CH = 3;
    localparam int unsigned STATUS_W     = 8;
    localparam int unsigned WDATA_W      = 2;
    localparam int unsigned PD_BIT       = 0;
    localparam int unsigned EN_BIT       = 1;
    localparam int unsigned FLAG_BIT     = 4;

    typedef struct packed {
        logic ot_flag;
        logic tsd_en;
        logic pd;
    } ctrl_t;

    function automatic logic [STATUS_W-1:0] pack_status(ctrl_t c);
        logic [STATUS_W-1:0] s;
        s           = '0;
        s[PD_BIT]   = c.pd;
        s[EN_BIT]   = c.tsd_en;
        s[FLAG_BIT] = c.ot_flag;
        return s;
    endfunction

    function automatic reg_kind_e next_kind(reg_kind_e k);
        case (k)
            KIND_DATA: return KIND_GAIN;
            KIND_GAIN: return KIND_OFFSET;
            default:   return KIND_DATA;
        endcase
    endfunction

endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{INIT}};
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rp_seq.sv
module rp_seq
    import rp_pkg::*;
#(
    parameter int unsigned NUM_CH     = 40,
    parameter int unsigned SEQ_CYCLES = 60000,
    localparam int unsigned CH_W      = $clog2(NUM_CH),
    localparam int unsigned CNT_W     = $clog2(SEQ_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output logic            strobe,
    output logic [CH_W-1:0] ch,
    output reg_kind_e       kind
);
    logic             busy_q, loading_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ch_q;
    reg_kind_e        kind_q;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEQ_CYCLES - 1);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            loading_q <= 1'b0;
            cnt_q     <= '0;
            ch_q      <= '0;
            kind_q    <= KIND_DATA;
        end else if (start) begin
            busy_q    <= 1'b1;
            loading_q <= 1'b1;
            cnt_q     <= '0;
            ch_q      <= '0;
            kind_q    <= KIND_DATA;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_CNT) begin
                busy_q    <= 1'b0;
                loading_q <= 1'b0;
            end else if (loading_q) begin
                kind_q <= next_kind(kind_q);
                if (kind_q == KIND_OFFSET) begin
                    if (ch_q == LAST_CH) loading_q <= 1'b0;
                    else                 ch_q <= ch_q + 1'b1;
                end
            end
        end
    end

    assign busy   = busy_q;
    assign strobe = busy_q & loading_q;
    assign ch     = ch_q;
    assign kind   = kind_q;
endmodule

// File: rtl/rp_ctrl.sv
module rp_ctrl
    import rp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               we,
    input  logic [WDATA_W-1:0] wdata,
    input  logic               inhibit,
    input  logic               ot,
    output ctrl_t              ctrl
);
    ctrl_t c_q;
    logic  wr_ok;

    assign wr_ok = we & ~inhibit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            c_q <= '0;
        end else begin
            if (wr_ok) begin
                c_q.pd     <= wdata[PD_BIT];
                c_q.tsd_en <= wdata[EN_BIT];
            end
            if (wr_ok && !wdata[EN_BIT]) c_q.ot_flag <= 1'b0;
            else if (c_q.tsd_en && ot)   c_q.ot_flag <= 1'b1;
        end
    end

    assign ctrl = c_q;
endmodule

// File: rtl/dac_rst_pwr_ctrl.sv
module dac_rst_pwr_ctrl
    import rp_pkg::*;
#(
    parameter int unsigned NUM_CH      = 40,
    parameter int unsigned SEQ_CYCLES  = 60000,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CH_W       = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rst_pin_n,
    input  logic                ot_in,
    input  logic                ctrl_we,
    input  logic [WDATA_W-1:0]  ctrl_wdata,
    output logic                load_strobe,
    output logic [CH_W-1:0]     load_ch,
    output logic [1:0]          load_kind,
    output logic                wr_inhibit,
    output logic                pwr_down,
    output logic [STATUS_W-1:0] status
);
    logic      pin_s, pin_d, start, ot_s, busy;
    reg_kind_e kind;
    ctrl_t     ctrl;

    rp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
        .clk(clk), .rst(rst), .d(rst_pin_n), .q(pin_s)
    );

    rp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ot_sync (
        .clk(clk), .rst(rst), .d(ot_in), .q(ot_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_d <= 1'b1;
        else     pin_d <= pin_s;
    end

    assign start = pin_s & ~pin_d;

    rp_seq #(.NUM_CH(NUM_CH), .SEQ_CYCLES(SEQ_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .strobe(load_strobe), .ch(load_ch), .kind(kind)
    );

    rp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .clr(start), .we(ctrl_we), .wdata(ctrl_wdata),
        .inhibit(busy), .ot(ot_s), .ctrl(ctrl)
    );

    assign load_kind  = kind;
    assign wr_inhibit = busy;
    assign pwr_down   = ctrl.pd | ctrl.ot_flag;
    assign status     = pack_status(ctrl);
endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
    parameter int unsigned NUM_CH = 40,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input logic            clk,
    input logic            rst,
    input logic            ctrl_we,
    input logic            load_strobe,
    input logic [CH_W-1:0] load_ch,
    input logic [1:0]      load_kind,
    input logic            wr_inhibit,
    input logic            pwr_down,
    input logic [7:0]      status
);
    a_r3_index_in_range: assert property (@(posedge clk) disable iff (rst)
        load_strobe |-> (int'(load_ch) < NUM_CH) && (load_kind != 2'd3));

    a_r2_strobe_inside_window: assert property (@(posedge clk) disable iff (rst)
        load_strobe |-> wr_inhibit);

    a_r4_pd_drives_output: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> pwr_down);

    a_r5_flag_drives_output: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> pwr_down);

    a_r7_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> status[1]);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[4] && status[1]) |=> (status[4] || !status[1]));

    a_r8_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (wr_inhibit && ctrl_we) |=> (status[1:0] == $past(status[1:0])) || (status[1:0] == 2'b00));
endmodule

bind dac_rst_pwr_ctrl rp_checker #(.NUM_CH(NUM_CH)) u_rp_checker (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .load_strobe(load_strobe),
    .load_ch(load_ch), .load_kind(load_kind), .wr_inhibit(wr_inhibit),
    .pwr_down(pwr_down), .status(status)
);

// File: tb/dac_rst_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module dac_rst_pwr_ctrl_bench;
    localparam int NCH = 8;
    localparam int SEQ = 40;
    localparam int CHW = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           pin = 1'b1;
    logic           ot  = 1'b0;
    logic           we  = 1'b0;
    logic [1:0]     wd  = 2'b00;
    logic           strobe, inhibit, pd;
    logic [CHW-1:0] ch;
    logic [1:0]     kind;
    logic [7:0]     status;

    int checks = 0;
    int errs   = 0;
    int exp_q[$];
    bit sb_on  = 1'b0;
    bit quiet  = 1'b0;

    always #2.5 clk = ~clk;

    dac_rst_pwr_ctrl #(.NUM_CH(NCH), .SEQ_CYCLES(SEQ)) u_dac_rst_pwr_ctrl (
        .clk(clk), .rst(rst), .rst_pin_n(pin), .ot_in(ot), .ctrl_we(we),
        .ctrl_wdata(wd), .load_strobe(strobe), .load_ch(ch), .load_kind(kind),
        .wr_inhibit(inhibit), .pwr_down(pd), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    endtask

    // monitor: scoreboard of default-load strobes
    always @(negedge clk) begin
        if (!rst && strobe) begin
            if (sb_on) begin
                if (exp_q.size() == 0) chk(1'b0, "R3 extra strobe", int'(ch) * 4 + int'(kind), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(ch) * 4 + int'(kind) == e, "R3 strobe order", int'(ch) * 4 + int'(kind), e);
                end
            end else if (quiet) begin
                chk(1'b0, "R1 strobe while pin held", 1, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] d);
        @(negedge clk); #1;
        we = 1'b1; wd = d;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    task automatic pin_low(input int n);
        @(negedge clk); #1;
        pin = 1'b0;
        tick(n);
    endtask

    task automatic run_seq(input string tag);
        int n;
        @(negedge clk); #1;
        pin = 1'b1;
        tick(2);
        exp_q.delete();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 3; k++) exp_q.push_back(c * 4 + k);
        sb_on = 1'b1;
        n = 0;
        @(negedge clk);
        while (inhibit) begin
            n++;
            @(negedge clk);
        end
        #1;
        chk(n == SEQ, {tag, " R2 inhibit length"}, n, SEQ);
        chk(exp_q.size() == 0, {tag, " R3 strobes left"}, exp_q.size(), 0);
        sb_on = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        chk(status == 8'h00, "R11 status", status, 0);
        chk(!inhibit && !pd && !strobe, "R11 outputs", {inhibit, pd, strobe}, 0);

        // R1: held low starts nothing
        quiet = 1'b1;
        pin_low(20);
        chk(!inhibit, "R1 inhibit while low", inhibit, 0);
        quiet = 1'b0;
        run_seq("R2/R3 first");

        // R4 power-down bit
        wr(2'b01); tick(1);
        chk(status == 8'h01 && pd, "R4 pd set", {status, pd}, 9'h003);
        wr(2'b00); tick(1);
        chk(status == 8'h00 && !pd, "R4 pd clear", {status, pd}, 0);

        // R6 ot ignored without enable
        ot = 1'b1; tick(6);
        chk(status == 8'h00 && !pd, "R6 ot ignored", {status, pd}, 0);

        // R5 enable then over-temp
        wr(2'b10); tick(3);
        chk(status == 8'h12 && pd, "R5 flag set", {status, pd}, 9'h025);

        // R7 sticky after cooling
        ot = 1'b0; tick(6);
        chk(status == 8'h12 && pd, "R7 flag held", {status, pd}, 9'h025);
        wr(2'b10); tick(2);
        chk(status == 8'h12, "R7 enable rewrite keeps flag", status, 8'h12);
        wr(2'b00); tick(2);
        chk(status == 8'h00 && !pd, "R7 flag cleared", {status, pd}, 0);

        // R9 sequence clears control; R8 writes during inhibit ignored
        wr(2'b11); ot = 1'b1; tick(5);
        chk(status == 8'h13, "R9 pre-state", status, 8'h13);
        ot = 1'b0;
        pin_low(3);
        chk(status == 8'h13, "R1 falling edge keeps state", status, 8'h13);
        fork
            run_seq("R9");
            begin
                tick(8);
                chk(status == 8'h00 && !pd, "R9 cleared at start", {status, pd}, 0);
                wr(2'b11);
                tick(2);
                chk(status == 8'h00 && !pd, "R8 write ignored", {status, pd}, 0);
            end
        join
        chk(status == 8'h00, "R8 after sequence", status, 0);

        // R10 restart mid-sequence
        pin_low(3);
        @(negedge clk); #1;
        pin = 1'b1;
        tick(12);
        pin_low(4);
        chk(inhibit == 1'b1, "R10 still inhibited", inhibit, 1);
        run_seq("R10");

        finish_up();
    end
endmodule